// File: doc/BRIEF.md
# Collision, Heartbeat and Carrier Sense Generator

This block produces the collision and carrier sense indications that a 10 Mb/s twisted-pair transceiver presents to its MAC. It watches three activity inputs: the transmitter is busy, the squelch has found valid receive data, and a jabber condition exists. It also reads two configuration levels, full duplex and heartbeat disable. From these it drives the collision line and the carrier line, both with no clock delay from the activity inputs.

The collision line carries two kinds of event. The first is a real collision: transmit and receive overlap in half duplex, or jabber is present in either mode. The second is the heartbeat, also called the signal quality test. Once a transmission ends, a programmable number of clock cycles passes, and then a pulse of programmable length appears on the collision line. The heartbeat is withheld in full duplex and while heartbeat disable is set. A new transmission that starts before the heartbeat is complete cancels it.

Carrier sense follows the receive qualifier. In half duplex it also follows the transmitter. It drops as soon as the activity that held it ends.

Top module: `col_crs_ctrl`

## Requirements
- R1: In half duplex (`full_duplex`=0), `col` is 1 in every cycle in which `tx_active` and `rx_valid` are both 1, with no clock delay.
- R2: In full duplex (`full_duplex`=1), overlapping `tx_active` and `rx_valid` does not drive `col` high.
- R3: `col` is 1 in every cycle in which `jabber` is 1, whatever the duplex mode.
- R4: Let edge E be the first rising clock edge at which `tx_active` is sampled 0 after being sampled 1 at the edge before. If no cancel occurs, `col` goes high right after edge E+SQE_DELAY_CYC. It stays high for exactly SQE_WIDTH_CYC cycles.
- R5: A clock edge that samples `full_duplex`=1 or `hb_disable`=1 while a heartbeat is pending or being driven cancels it. A transmission that ends while either level is 1 produces no heartbeat.
- R6: A clock edge that samples `tx_active`=1 while a heartbeat is pending or being driven cancels it. Only a later end of transmission starts a new heartbeat.
- R7: In half duplex, `crs` equals `tx_active` OR `rx_valid`, with no clock delay.
- R8: In full duplex, `crs` equals `rx_valid`, and transmit activity has no effect on it.
- R9: While `rst_n` is 0, and after its release with all inputs 0, `col` and `crs` are 0 and no heartbeat is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_active | input | 1 | Transmitter is sending a packet |
| rx_valid | input | 1 | Squelch reports valid receive data |
| jabber | input | 1 | Jabber condition detected |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| hb_disable | input | 1 | 1 = heartbeat suppressed |
| col | output | 1 | Collision indication, including heartbeat pulses |
| crs | output | 1 | Carrier sense |

## Verification
The hardest case to reach from the ports is a heartbeat cut short by a cancelling event: a transmission that restarts, or a configuration change, in the single cycle just before the pulse would start, or in its last cycle. Random traffic rarely lands on those cycles. Directed sequences therefore count cycles from the end of a transmission and place the event on each of those edges. Random bursts with short gaps, occasional jabber and rare mode changes then exercise the rest against a cycle model in the bench.

// File: rtl/col_crs_ctrl.sv
module col_crs_ctrl #(
  parameter int SQE_DELAY_CYC = 250,
  parameter int SQE_WIDTH_CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  input  logic rx_valid,
  input  logic jabber,
  input  logic full_duplex,
  input  logic hb_disable,
  output logic col,
  output logic crs
);

  localparam int MAXC  = (SQE_DELAY_CYC > SQE_WIDTH_CYC) ? SQE_DELAY_CYC : SQE_WIDTH_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(SQE_DELAY_CYC - 1);
  localparam logic [CNT_W-1:0] WID_LAST = CNT_W'(SQE_WIDTH_CYC - 1);

  typedef enum logic [1:0] {HB_IDLE, HB_WAIT, HB_PULSE} hb_state_t;

  hb_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic             tx_prev;
  logic             hb_block;
  logic             tx_end;
  logic             sqe_on;
  logic             overlap;

  assign hb_block = full_duplex | hb_disable;
  assign tx_end   = tx_prev & ~tx_active;
  assign sqe_on   = (state == HB_PULSE);
  assign overlap  = ~full_duplex & tx_active & rx_valid;

  assign col = overlap | jabber | sqe_on;
  assign crs = rx_valid | (~full_duplex & tx_active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= HB_IDLE;
      cnt     <= '0;
      tx_prev <= 1'b0;
    end else begin
      tx_prev <= tx_active;
      case (state)
        HB_IDLE: begin
          cnt <= '0;
          if (tx_end && !hb_block) state <= HB_WAIT;
        end
        HB_WAIT: begin
          if (tx_active || hb_block) begin
            state <= HB_IDLE;
            cnt   <= '0;
          end else if (cnt == DLY_LAST) begin
            state <= HB_PULSE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        HB_PULSE: begin
          if (tx_active || hb_block || cnt == WID_LAST) begin
            state <= HB_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= HB_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  p_jabber_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
    jabber |-> col);

  p_fd_crs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (full_duplex && !rx_valid) |-> !crs);

  p_sqe_after_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sqe_on) |-> $past(state == HB_WAIT));

  p_sqe_not_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sqe_on |-> (!$past(full_duplex) && !$past(hb_disable)));

  p_sqe_tx_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sqe_on |-> !$past(tx_active));

  p_wait_from_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HB_WAIT && $past(state) == HB_IDLE) |-> ($past(tx_prev) && !$past(tx_active)));

endmodule

// File: tb/col_crs_ctrl_tb.sv
module col_crs_ctrl_tb;
  localparam int DLY = 6;
  localparam int WID = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx = 0, rx = 0, jab = 0, fd = 0, hbd = 0;
  logic col, crs;

  int checks = 0;
  int errors = 0;
  int gap = 0;
  bit prevtx = 0;
  bit done = 0;
  string tag = "R4";

  always #2 clk = ~clk;

  col_crs_ctrl #(.SQE_DELAY_CYC(DLY), .SQE_WIDTH_CYC(WID)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_active(tx), .rx_valid(rx), .jabber(jab),
    .full_duplex(fd), .hb_disable(hbd), .col(col), .crs(crs));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= 0; prevtx <= 0;
    end else if (tx) begin
      gap <= 0; prevtx <= 1;
    end else begin
      prevtx <= 0;
      if (fd || hbd) gap <= 0;
      else if (prevtx) gap <= 1;
      else if (gap != 0 && gap < DLY + WID) gap <= gap + 1;
      else gap <= 0;
    end
  end

  function automatic bit exp_col(bit t, bit r, bit j, bit f, int g);
    return (!f && t && r) || j || (g > DLY);
  endfunction

  function automatic bit exp_crs(bit t, bit r, bit f);
    return r || (!f && t);
  endfunction

  task automatic check_now();
    bit ec = exp_col(tx, rx, jab, fd, gap);
    bit es = exp_crs(tx, rx, fd);
    string cl = jab ? "R3" : (tx && rx) ? (fd ? "R2" : "R1") : tag;
    string sl = fd ? "R8" : "R7";
    checks += 2;
    if (col !== ec) begin
      errors++;
      $display("FAIL %s col: actual %b expected %b (t=%0t)", cl, col, ec, $time);
    end
    if (crs !== es) begin
      errors++;
      $display("FAIL %s crs: actual %b expected %b (t=%0t)", sl, crs, es, $time);
    end
  endtask

  task automatic step(bit t, bit r, bit j, bit f, bit h);
    @(negedge clk);
    check_now();
    tx = t; rx = r; jab = j; fd = f; hbd = h;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, fd, hbd);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    tag = "R9";
    repeat (3) @(negedge clk);
    check_now();
    rst_n = 1'b1;
    idle(3);

    tag = "R4";
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0);
    idle(DLY + WID + 4);

    tag = "R6";
    for (int k = DLY - 1; k <= DLY + WID - 1; k++) begin
      for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0);
      idle(k);
      step(1, 0, 0, 0, 0);
      step(1, 1, 0, 0, 0);
      idle(DLY + WID + 3);
    end

    tag = "R5";
    for (int k = DLY - 1; k <= DLY + 1; k++) begin
      for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0);
      idle(k);
      step(0, 0, 0, 0, 1);
      step(0, 0, 0, 0, 0);
      idle(DLY + WID + 2);
    end
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 1);
    idle(DLY + WID + 3);
    for (int i = 0; i < 3; i++) step(1, 1, 0, 1, 0);
    idle(DLY + WID + 3);
    step(0, 0, 0, 0, 0);

    tag = "R3";
    step(0, 0, 1, 1, 0);
    step(1, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0);

    tag = "R4";
    for (int n = 0; n < 3000; n++) begin
      bit t = ($urandom_range(0, 3) != 0) ? tx : ~tx;
      bit r = ($urandom_range(0, 4) == 0);
      bit j = ($urandom_range(0, 40) == 0);
      bit f = ($urandom_range(0, 150) == 0) ? ~fd : fd;
      bit h = ($urandom_range(0, 150) == 0) ? ~hbd : hbd;
      step(t, r, j, f, h);
    end
    idle(DLY + WID + 2);

    done = 1;
    finish_run();
  end
endmodule